// File: doc/BRIEF.md
# Event Performance Counter Unit

This block gathers hardware event statistics for a processor subsystem. It holds four 32-bit event counters and one 32-bit cycle counter, all reached through a small synchronous register bus made of a word address, a write strobe, write data and combinational read data. Each event counter is bound to one source by an 8-bit event code. The code can pick a line of the event input vector, every clock cycle, or a software-triggered increment.

Software picks an event counter through a selection register and then reaches its event code and count through two shared access registers. The cycle counter has its own data register. Counter enables, interrupt enables and overflow flags are bitmasks. The event counters use bits 0 to 3 and the cycle counter uses bit 31. Enables are changed through paired write-one-to-set and write-one-to-clear addresses. When a counter wraps it raises its overflow flag, and a flag that is also interrupt-enabled drives the interrupt output.

Top module: `perf_counter_unit`

## Requirements
- R1: Every counter is 32 bits wide. It adds exactly one per clock edge on which it is advanced, and it wraps from 0xFFFFFFFF to 0.
- R2: Writing address 0x1 sets the enable bits marked by ones in the data, and writing address 0x2 clears them. Bit n enables event counter n and bit 31 enables the cycle counter. Zero bits leave their enables unchanged, and both addresses read back the enable mask.
- R3: Interrupt enables use the same bit positions and the same scheme: address 0x3 sets bits and address 0x4 clears them, and both addresses read back the mask.
- R4: The flag register at address 0x5 has bit n set when event counter n wraps and bit 31 set when the cycle counter wraps. Writing a one to a flag bit clears it. If a wrap and a clearing write to the same bit fall in the same cycle, the flag ends up set.
- R5: The output irq is high exactly when some flag bit and its interrupt-enable bit are both set.
- R6: Bit 0 of the control register at address 0x0 is the global enable, and no counter advances while it is clear. Bits 15:11 of that register are read-only and read 4, the number of event counters.
- R7: The selection register at address 0x6 holds an 8-bit counter index. The event-code register at 0x7 and the count register at 0x8 read and write the selected counter.
- R8: While the selection value is 4 or more, addresses 0x7 and 0x8 read as zero and writes to them change nothing.
- R9: Event code 0x11 advances a counter on every cycle. A code c from 0x01 to 0x1D, other than 0x11, advances the counter on cycles where event input line c-1 is high. Codes 0x1E to 0xFF never advance it.
- R10: A write to address 0xA with bit n set advances event counter n by one, but only when that counter's code is 0x00. Counters with any other code ignore it.
- R11: The cycle counter is read and written at address 0x9. It advances on every cycle in which the global enable and enable bit 31 are both set.
- R12: When a bus write to a counter and an increment of that counter fall in the same cycle, the counter takes the written value.
- R13: Reset clears all counters, enables, interrupt enables, flags, event codes, the selection register and the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 29 | Event input lines; line k is selected by code k+1 |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land on the same clock edge. A bus write to a counter can coincide with that counter's own increment, and a write that clears a flag can coincide with the wrap that sets the flag. The bench provokes the first by writing a counter that is counting every cycle, then reading it back before the next edge, where it expects exactly the written value. It provokes the second by placing the flag-clearing write on the very edge where a counter preloaded with 0xFFFFFFFF wraps, and then expects the flag set and the counter at zero. A sweep over all four counters and a wide range of event codes checks the event line selection arithmetically.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 4;
  localparam int CYC_BIT  = 31;
  localparam int NCNT_LSB = 11;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_EN_SET = 4'h1;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 4'h2;
  localparam logic [ADDR_W-1:0] A_IE_SET = 4'h3;
  localparam logic [ADDR_W-1:0] A_IE_CLR = 4'h4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h5;
  localparam logic [ADDR_W-1:0] A_SEL    = 4'h6;
  localparam logic [ADDR_W-1:0] A_EVCODE = 4'h7;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'h8;
  localparam logic [ADDR_W-1:0] A_CYCLES = 4'h9;
  localparam logic [ADDR_W-1:0] A_SWINC  = 4'hA;

  localparam logic [7:0] EV_SWINC  = 8'h00;
  localparam logic [7:0] EV_CYCLES = 8'h11;
  localparam logic [7:0] EV_LAST   = 8'h1D;
endpackage

// File: rtl/perfmon_event_mux.sv
module perfmon_event_mux
  import perfmon_pkg::*;
#(
  parameter int EVT_LINES = 29
) (
  input  logic [7:0]           code,
  input  logic [EVT_LINES-1:0] lines,
  input  logic                 sw_pulse,
  output logic                 hit
);
  always_comb begin
    hit = 1'b0;
    if (code == EV_SWINC) begin
      hit = sw_pulse;
    end else if (code == EV_CYCLES) begin
      hit = 1'b1;
    end else if (code <= EV_LAST) begin
      for (int k = 0; k < EVT_LINES; k++) begin
        if (code == 8'(k + 1)) hit = lines[k];
      end
    end
  end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)    cnt_d = wr_data;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  assign cnt_ce = wr_en | inc;
  assign wrap   = inc & ~wr_en & (&cnt_q);
  assign value  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr_en) |=> (cnt_q == $past(cnt_q) + W'(1)));

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perfmon_pkg::*;
#(
  parameter int NCNT      = 4,
  parameter int EVT_LINES = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [EVT_LINES-1:0] evt_in,
  output logic                 irq
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    ((DATA_W'(1) << NCNT) - DATA_W'(1)) | (DATA_W'(1) << CYC_BIT);

  logic              unit_en_q, unit_en_d;
  logic [DATA_W-1:0] en_q, en_d, ie_q, ie_d, flg_q, flg_d;
  logic [7:0]        sel_q;
  logic [7:0]        code_q [NCNT];
  logic [DATA_W-1:0] cnt_val [NCNT];
  logic [DATA_W-1:0] cyc_val;
  logic [DATA_W-1:0] wrap_vec;
  logic              sel_ok;
  logic ctrl_we, ens_we, enc_we, ies_we, iec_we, flg_we, sel_we;
  logic code_we, cnt_we, cyc_we, sw_we, flg_ce;

  assign ctrl_we = bus_wr && (bus_addr == A_CTRL);
  assign ens_we  = bus_wr && (bus_addr == A_EN_SET);
  assign enc_we  = bus_wr && (bus_addr == A_EN_CLR);
  assign ies_we  = bus_wr && (bus_addr == A_IE_SET);
  assign iec_we  = bus_wr && (bus_addr == A_IE_CLR);
  assign flg_we  = bus_wr && (bus_addr == A_FLAGS);
  assign sel_we  = bus_wr && (bus_addr == A_SEL);
  assign code_we = bus_wr && (bus_addr == A_EVCODE);
  assign cnt_we  = bus_wr && (bus_addr == A_COUNT);
  assign cyc_we  = bus_wr && (bus_addr == A_CYCLES);
  assign sw_we   = bus_wr && (bus_addr == A_SWINC);
  assign sel_ok  = (sel_q < 8'(NCNT));

  // next state of the mask and control registers
  always_comb begin
    unit_en_d = ctrl_we ? bus_wdata[0] : unit_en_q;
    en_d = en_q;
    if (ens_we) en_d = en_q | (bus_wdata & IMPL_MASK);
    if (enc_we) en_d = en_q & ~bus_wdata;
    ie_d = ie_q;
    if (ies_we) ie_d = ie_q | (bus_wdata & IMPL_MASK);
    if (iec_we) ie_d = ie_q & ~bus_wdata;
    // a wrap in the same cycle outranks a clearing write
    flg_d = (flg_q & ~(flg_we ? bus_wdata : '0)) | wrap_vec;
  end

  assign flg_ce = flg_we | (|wrap_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_en_q <= 1'b0;
      en_q      <= '0;
      ie_q      <= '0;
      flg_q     <= '0;
      sel_q     <= '0;
    end else begin
      if (ctrl_we)         unit_en_q <= unit_en_d;
      if (ens_we | enc_we) en_q      <= en_d;
      if (ies_we | iec_we) ie_q      <= ie_d;
      if (flg_ce)          flg_q     <= flg_d;
      if (sel_we)          sel_q     <= bus_wdata[7:0];
    end
  end

  for (genvar i = 0; i < NCNT; i++) begin : g_evt
    logic hit, inc, hit_sel;
    assign hit_sel = sel_ok && (sel_q == 8'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   code_q[i] <= '0;
      else if (code_we && hit_sel)  code_q[i] <= bus_wdata[7:0];
    end

    perfmon_event_mux #(.EVT_LINES(EVT_LINES)) u_mux (
      .code     (code_q[i]),
      .lines    (evt_in),
      .sw_pulse (sw_we & bus_wdata[i]),
      .hit      (hit)
    );

    assign inc = unit_en_q & en_q[i] & hit;

    perfmon_counter #(.W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .wr_en   (cnt_we && hit_sel),
      .wr_data (bus_wdata),
      .value   (cnt_val[i]),
      .wrap    (wrap_vec[i])
    );

    assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!unit_en_q && !cnt_we) |=> $stable(cnt_val[i]));
  end

  if (CYC_BIT > NCNT) begin : g_gap
    assign wrap_vec[CYC_BIT-1:NCNT] = '0;
  end

  perfmon_counter #(.W(DATA_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (unit_en_q & en_q[CYC_BIT]),
    .wr_en   (cyc_we),
    .wr_data (bus_wdata),
    .value   (cyc_val),
    .wrap    (wrap_vec[CYC_BIT])
  );

  // read data
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:             bus_rdata = {16'd0, 5'(NCNT), 10'd0, unit_en_q};
      A_EN_SET, A_EN_CLR: bus_rdata = en_q;
      A_IE_SET, A_IE_CLR: bus_rdata = ie_q;
      A_FLAGS:            bus_rdata = flg_q;
      A_SEL:              bus_rdata = {24'd0, sel_q};
      A_EVCODE: for (int k = 0; k < NCNT; k++)
                  if (sel_q == 8'(k)) bus_rdata = {24'd0, code_q[k]};
      A_COUNT:  for (int k = 0; k < NCNT; k++)
                  if (sel_q == 8'(k)) bus_rdata = cnt_val[k];
      A_CYCLES:           bus_rdata = cyc_val;
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = |(flg_q & ie_q);

  assert_hold_cyc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_en_q && !cyc_we) |=> $stable(cyc_val));

  assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ens_we |=> ((en_q & $past(bus_wdata & IMPL_MASK)) == $past(bus_wdata & IMPL_MASK)));

  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && !(|wrap_vec)) |=> ((flg_q & $past(bus_wdata)) == '0));

  assert_badsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && (bus_addr == A_EVCODE || bus_addr == A_COUNT)) |-> (bus_rdata == '0));

  assert_irq_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_q == '0) |-> !irq);
endmodule

// File: tb/tb_perf_counter_unit.sv
module tb_perf_counter_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [28:0] evt_in;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  perf_counter_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; evt_in = '0;
    @(negedge clk);
    do_reset();

    // R13 reset state, R6 counter-count field
    rd("R6 ctrl reset", 4'h0, 32'h0000_2000);
    for (int a = 1; a < 16; a++) rd("R13 reset reg", 4'(a), 32'h0);
    check("R5 irq reset", {31'd0, irq}, 32'h0);

    // R9 / R7 sweep over counters and codes
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 34; j++) begin
        logic [7:0] c;
        logic [31:0] exp;
        c = (j < 32) ? 8'(j) : ((j == 32) ? 8'h80 : 8'hFF);
        wr(4'h0, 0);
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h1, 32'h1 << i);
        wr(4'h6, 32'(i));
        wr(4'h7, {24'd0, c});
        wr(4'h8, 0);
        if (c >= 8'h01 && c <= 8'h1D && c != 8'h11) evt_in = 29'h1 << (c - 8'h1);
        else evt_in = '1;
        wr(4'h0, 1);
        repeat (2) @(negedge clk);
        wr(4'h0, 0);
        evt_in = '0;
        exp = (c >= 8'h01 && c <= 8'h1D) ? 32'd3 : 32'd0;
        rd("R9 code sweep", 4'h8, exp);
        rd("R7 code readback", 4'h7, {24'd0, c});
      end
    end

    // R11 cycle counter wraps, R4 flag bit 31, R5 irq
    wr(4'h2, 32'hFFFF_FFFF);
    wr(4'h1, 32'h8000_0000);
    rd("R2 enable mask", 4'h2, 32'h8000_0000);
    wr(4'h9, 32'hFFFF_FFFE);
    rd("R11 cycle write", 4'h9, 32'hFFFF_FFFE);
    wr(4'h5, 32'hFFFF_FFFF);
    wr(4'h0, 1);
    repeat (4) @(negedge clk);
    wr(4'h0, 0);
    rd("R11 cycle count", 4'h9, 32'h0000_0003);
    rd("R4 cycle flag", 4'h5, 32'h8000_0000);
    check("R5 irq masked", {31'd0, irq}, 32'h0);
    wr(4'h3, 32'h8000_0000);
    rd("R3 ie set", 4'h3, 32'h8000_0000);
    check("R5 irq raised", {31'd0, irq}, 32'h1);
    wr(4'h4, 32'h8000_0000);
    rd("R3 ie clear", 4'h4, 32'h0);
    check("R5 irq after ie clear", {31'd0, irq}, 32'h0);
    wr(4'h3, 32'h8000_0000);
    wr(4'h5, 32'h8000_0000);
    rd("R4 flag cleared", 4'h5, 32'h0);
    check("R5 irq after flag clear", {31'd0, irq}, 32'h0);

    // R6 global enable off; R2 counter enable off
    wr(4'h6, 1);
    wr(4'h7, 32'h05);
    wr(4'h8, 32'h10);
    wr(4'h1, 32'h2);
    evt_in = 29'h10;
    repeat (3) @(negedge clk);
    rd("R6 unit off no count", 4'h8, 32'h10);
    wr(4'h2, 32'h2);
    wr(4'h1, 32'h0);
    rd("R2 zero bits keep", 4'h1, 32'h8000_0000);
    wr(4'h0, 1);
    repeat (3) @(negedge clk);
    wr(4'h0, 0);
    evt_in = '0;
    rd("R2 disabled no count", 4'h8, 32'h10);

    // R12 write wins over increment
    wr(4'h6, 2);
    wr(4'h7, 32'h11);
    wr(4'h1, 32'h4);
    wr(4'h0, 1);
    wr(4'h8, 32'h1234);
    rd("R12 write wins", 4'h8, 32'h1234);
    @(negedge clk);
    rd("R1 step after write", 4'h8, 32'h1235);
    wr(4'h0, 0);

    // R4 overflow set beats clearing write on the same edge
    wr(4'h6, 3);
    wr(4'h7, 32'h02);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h1, 32'h8);
    wr(4'h5, 32'hFFFF_FFFF);
    evt_in = 29'h2;
    wr(4'h0, 1);
    wr(4'h5, 32'h8);
    evt_in = '0;
    wr(4'h0, 0);
    rd("R1 wrap to zero", 4'h8, 32'h0);
    rd("R4 set beats clear", 4'h5, 32'h8);
    wr(4'h5, 32'h8);
    rd("R4 write one clears", 4'h5, 32'h0);

    // R10 software increment
    wr(4'h6, 0);
    wr(4'h7, 32'h00);
    wr(4'h8, 32'h0);
    wr(4'h1, 32'h3);
    wr(4'h6, 1);
    wr(4'h8, 32'h7);
    wr(4'h0, 1);
    wr(4'hA, 32'h3);
    wr(4'hA, 32'hC);
    wr(4'h0, 0);
    rd("R10 other code ignores", 4'h8, 32'h7);
    wr(4'h6, 0);
    rd("R10 sw increment", 4'h8, 32'h1);

    // R8 out-of-range selection
    wr(4'h6, 4);
    rd("R7 select readback", 4'h6, 32'h4);
    rd("R8 code reads zero", 4'h7, 32'h0);
    rd("R8 count reads zero", 4'h8, 32'h0);
    wr(4'h7, 32'h11);
    wr(4'h8, 32'h55);
    wr(4'h6, 32'hFF);
    wr(4'h8, 32'h66);
    rd("R8 count reads zero ff", 4'h8, 32'h0);
    for (int i = 0; i < 4; i++) begin
      wr(4'h6, 32'(i));
      rd("R8 code untouched", 4'h7, (i == 0) ? 32'h00 : ((i == 1) ? 32'h05 : ((i == 2) ? 32'h11 : 32'h02)));
    end
    wr(4'h6, 0);
    rd("R8 count untouched", 4'h8, 32'h1);

    // R13 reset mid-run
    wr(4'h0, 1);
    wr(4'h3, 32'hF);
    do_reset();
    rd("R13 ctrl after reset", 4'h0, 32'h0000_2000);
    rd("R13 count after reset", 4'h8, 32'h0);
    rd("R13 enables after reset", 4'h1, 32'h0);
    rd("R13 ie after reset", 4'h3, 32'h0);
    rd("R13 cycles after reset", 4'h9, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule